// File: doc/BRIEF.md
# Masked-Write GPIO Register Bank

This block is a 32-pin general-purpose I/O bank set up through a simple word-wide register bus. It drives an output value and an output enable for each pin. It returns the pin levels, after synchronization, on read. It also holds the per-pin configuration vectors that a separate interrupt detector uses: enable, mask, level/edge type, polarity, both-edge and debounce. It passes that detector's status and raw status back to the bus, and it raises a one-cycle acknowledge pulse per pin.

Every 32-pin logical register is stored as two 16-bit halves at consecutive word addresses. The half at the base address serves pins 0..15 and the half at base+4 serves pins 16..31. A write carries its own bit-enable mask in the upper 16 bits of the written word. Software can therefore change any single pin without first reading the register.

Top module: `gpio_mw_bank`

## Requirements
- R1: After reset every stored configuration bit is 0: `pin_out`, `pin_oe` and all six interrupt configuration vectors are 0, so every pin is an input. `rd_valid` and `eoi_pulse` are also 0.
- R2: A write to a writable half updates stored bit n (0..15) to `wdata[n]` only when `wdata[n+16]` is 1. Every other stored bit keeps its value. The new value is visible on the outputs in the cycle after the write.
- R3: The half at the base offset controls pins 0..15. The half at base+4 controls pins 16..31. A write to one half leaves the other half unchanged.
- R4: A read presented with `rd_en` returns its result on `rdata` with `rd_valid` high one cycle later. For a stored half, the 16 stored bits appear in `rdata[15:0]` and `rdata[31:16]` is 0.
- R5: Output data sits at offset 0x00 and drives `pin_out`. Direction sits at 0x08 and drives `pin_oe`, where 1 means output and 0 means input.
- R6: The interrupt configuration vectors sit at these offsets: enable 0x10 (`irq_en`), mask 0x18 (`irq_mask`), level/edge type 0x20 (`irq_edge`), polarity 0x28 (`irq_pol`), both-edge 0x30 (`irq_both`) and debounce 0x38 (`irq_debounce`).
- R7: Offsets 0x70/0x74 return the pin input levels through a two-flop synchronizer. A level driven before rising edge k is returned by a read sampled at edge k+2, and not by one sampled at edge k+1.
- R8: Offsets 0x50/0x54 return `irq_status_in` and offsets 0x58/0x5C return `irq_raw_in`, 16 pins per half.
- R9: A write to 0x60/0x64 gives, in the next cycle only, a one-cycle pulse on `eoi_pulse` for each pin whose data bit and enable bit are both 1. Reads of these offsets return 0.
- R10: Offset 0x78 always reads 0x01000C2B, and writes to it have no effect.
- R11: All other offsets read 0 and writes to them are ignored. This covers any address with `addr[1:0]` not 00, 0x40..0x4C, 0x68, 0x6C, 0x7C and anything at or above 0x80.
- R12: When a read and a write to the same address fall in the same cycle, the read returns the value stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write word: enables in 31:16, data in 15:0 |
| rdata | output | 32 | Read result, valid with rd_valid |
| rd_valid | output | 1 | Read result present |
| pin_in | input | 32 | Raw pin input levels |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables |
| irq_en | output | 32 | Interrupt enable per pin |
| irq_mask | output | 32 | Interrupt mask per pin |
| irq_edge | output | 32 | Level (0) or edge (1) type per pin |
| irq_pol | output | 32 | Interrupt polarity per pin |
| irq_both | output | 32 | Both-edge select per pin |
| irq_debounce | output | 32 | Debounce enable per pin |
| irq_status_in | input | 32 | Masked status from the detector |
| irq_raw_in | input | 32 | Raw status from the detector |
| eoi_pulse | output | 32 | One-cycle acknowledge pulse per pin |

## Verification
A read and a masked write to the same half-register can occur in the same cycle. The bench provokes this by raising `rd_en` and `wr_en` together at offset 0x00. It requires the read to return the stored value from before the write, and then requires a second read to return the merged value. The bench also places back-to-back reads of the external port across a pin change. This shows the synchronizer delay as it meets the registered read path, and each read is judged against the edge at which it was sampled.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;
  localparam int HALF_W    = 16;
  localparam int BUS_W     = 2 * HALF_W;
  localparam int CFG_SLOTS = 8;

  // Slot = byte offset / 8; slots 0..7 are the stored configuration halves.
  localparam logic [4:0] SLOT_STAT = 5'd10;
  localparam logic [4:0] SLOT_RAW  = 5'd11;
  localparam logic [4:0] SLOT_EOI  = 5'd12;
  localparam logic [4:0] SLOT_EXT  = 5'd14;
  localparam logic [4:0] SLOT_VER  = 5'd15;

  localparam logic [BUS_W-1:0] VERSION_ID = 32'h01000C2B;

  typedef enum logic [2:0] {
    CFG_DATA = 3'd0, CFG_DIR = 3'd1, CFG_IEN = 3'd2, CFG_IMASK = 3'd3,
    CFG_EDGE = 3'd4, CFG_POL = 3'd5, CFG_BOTH = 3'd6, CFG_DEB = 3'd7
  } cfg_slot_e;

  // Masked merge: enables in the upper half select which data bits land.
  function automatic logic [HALF_W-1:0] mw_merge(input logic [HALF_W-1:0] old_q,
                                                 input logic [BUS_W-1:0]  word);
    logic [HALF_W-1:0] en;
    en = word[BUS_W-1:HALF_W];
    return (old_q & ~en) | (word[HALF_W-1:0] & en);
  endfunction

  // Bits that both carry a 1 and are enabled.
  function automatic logic [HALF_W-1:0] mw_set_bits(input logic [BUS_W-1:0] word);
    return word[HALF_W-1:0] & word[BUS_W-1:HALF_W];
  endfunction

  function automatic logic [HALF_W-1:0] half_of(input logic [BUS_W-1:0] v, input logic hi);
    return hi ? v[BUS_W-1:HALF_W] : v[HALF_W-1:0];
  endfunction
endpackage

// File: rtl/gpio_mw_half_reg.sv
module gpio_mw_half_reg
  import gpio_mw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [BUS_W-1:0]  wr_word,
  output logic [HALF_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (wr_stb) q <= mw_merge(q, wr_word);
  end
endmodule

// File: rtl/gpio_mw_sync.sv
module gpio_mw_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_mw_rdmux.sv
module gpio_mw_rdmux
  import gpio_mw_pkg::*;
(
  input  logic                                addr_ok,
  input  logic [4:0]                          slot,
  input  logic                                hi,
  input  logic [CFG_SLOTS-1:0][BUS_W-1:0]     cfg,
  input  logic [BUS_W-1:0]                    status,
  input  logic [BUS_W-1:0]                    raw,
  input  logic [BUS_W-1:0]                    ext,
  output logic [BUS_W-1:0]                    word
);
  always_comb begin
    word = '0;
    if (addr_ok) begin
      if (slot[4:3] == 2'b00) begin
        word[HALF_W-1:0] = half_of(cfg[slot[2:0]], hi);
      end else begin
        case (slot)
          SLOT_STAT: word[HALF_W-1:0] = half_of(status, hi);
          SLOT_RAW:  word[HALF_W-1:0] = half_of(raw, hi);
          SLOT_EXT:  word[HALF_W-1:0] = half_of(ext, hi);
          SLOT_VER:  word = hi ? '0 : VERSION_ID;
          default:   word = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_mw_bank.sv
module gpio_mw_bank
  import gpio_mw_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rd_valid,
  input  logic [31:0]       pin_in,
  output logic [31:0]       pin_out,
  output logic [31:0]       pin_oe,
  output logic [31:0]       irq_en,
  output logic [31:0]       irq_mask,
  output logic [31:0]       irq_edge,
  output logic [31:0]       irq_pol,
  output logic [31:0]       irq_both,
  output logic [31:0]       irq_debounce,
  input  logic [31:0]       irq_status_in,
  input  logic [31:0]       irq_raw_in,
  output logic [31:0]       eoi_pulse
);
  localparam int WIN_BITS = 8;

  // Decoded access fields, brought out as named wires.
  logic       addr_ok;
  logic [4:0] slot;
  logic       hi;
  logic       wr_cfg_hit;
  logic       wr_eoi_hit;

  assign addr_ok    = (addr[1:0] == 2'b00) && ((addr >> WIN_BITS) == '0);
  assign slot       = addr[7:3];
  assign hi         = addr[2];
  assign wr_cfg_hit = wr_en && addr_ok && (slot[4:3] == 2'b00);
  assign wr_eoi_hit = wr_en && addr_ok && (slot == SLOT_EOI);

  // Stored configuration: CFG_SLOTS logical registers, two halves each.
  logic [CFG_SLOTS-1:0][BUS_W-1:0] cfg;

  for (genvar g = 0; g < CFG_SLOTS; g++) begin : g_cfg
    for (genvar h = 0; h < 2; h++) begin : g_half
      logic stb;
      assign stb = wr_cfg_hit && (slot[2:0] == g[2:0]) && (hi == h[0]);
      gpio_mw_half_reg u_half (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (stb),
        .wr_word(wdata),
        .q      (cfg[g][h*HALF_W +: HALF_W])
      );
    end
  end

  assign pin_out      = cfg[CFG_DATA];
  assign pin_oe       = cfg[CFG_DIR];
  assign irq_en       = cfg[CFG_IEN];
  assign irq_mask     = cfg[CFG_IMASK];
  assign irq_edge     = cfg[CFG_EDGE];
  assign irq_pol      = cfg[CFG_POL];
  assign irq_both     = cfg[CFG_BOTH];
  assign irq_debounce = cfg[CFG_DEB];

  // Pin input synchronizer.
  logic [BUS_W-1:0] pin_sync;
  gpio_mw_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_in),
    .q    (pin_sync)
  );

  // End-of-interrupt acknowledge pulse.
  logic [BUS_W-1:0] eoi_next;
  always_comb begin
    eoi_next = '0;
    if (wr_eoi_hit) eoi_next[(hi ? HALF_W : 0) +: HALF_W] = mw_set_bits(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eoi_pulse <= '0;
    else        eoi_pulse <= eoi_next;
  end

  // Read path: registered, samples state from before any same-cycle write.
  logic [BUS_W-1:0] rd_word;
  gpio_mw_rdmux u_rdmux (
    .addr_ok(addr_ok),
    .slot   (slot),
    .hi     (hi),
    .cfg    (cfg),
    .status (irq_status_in),
    .raw    (irq_raw_in),
    .ext    (pin_sync),
    .word   (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rdata    <= rd_en ? rd_word : '0;
    end
  end
endmodule

// File: rtl/gpio_mw_bank_chk.sv
module gpio_mw_bank_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              rd_valid,
  input logic [31:0]       pin_out,
  input logic [31:0]       pin_oe,
  input logic [31:0]       eoi_pulse
);
  assert_keep_unmasked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 'h00) |=>
      (((pin_out[15:0] ^ $past(pin_out[15:0])) & ~$past(wdata[31:16])) == 16'h0));

  assert_take_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 'h00) |=>
      ((pin_out[15:0] & $past(wdata[31:16])) == ($past(wdata[15:0]) & $past(wdata[31:16]))));

  assert_other_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 'h04) |=> (pin_out[15:0] == $past(pin_out[15:0])));

  assert_rd_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  assert_no_spurious_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  assert_oe_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pin_oe));

  assert_eoi_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (eoi_pulse == 32'h0));

  assert_version_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 'h78) |=> (rdata == 32'h01000C2B));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 'h40) |=> (rdata == 32'h0));
endmodule

bind gpio_mw_bank gpio_mw_bank_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/gpio_mw_bank_tb.sv
module gpio_mw_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_valid;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe, irq_en, irq_mask, irq_edge, irq_pol, irq_both, irq_debounce;
  logic [31:0] irq_status_in = '0, irq_raw_in = '0;
  logic [31:0] eoi_pulse;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  gpio_mw_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_en(irq_en), .irq_mask(irq_mask),
    .irq_edge(irq_edge), .irq_pol(irq_pol), .irq_both(irq_both),
    .irq_debounce(irq_debounce), .irq_status_in(irq_status_in),
    .irq_raw_in(irq_raw_in), .eoi_pulse(eoi_pulse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as read results appear.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R4 unexpected read actual=%08h expected=none", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  // Driver tasks: called at a falling edge, return at the next falling edge.
  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_rw(input logic [7:0] a, input logic [31:0] d,
                       input logic [31:0] exp, input string tag);
    addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 irq_en", irq_en, 32'h0);
    check("R1 eoi", eoi_pulse, 32'h0);
    check("R1 rd_valid", {31'h0, rd_valid}, 32'h0);
    do_read(8'h08, 32'h0, "R1 dir read");

    // R2 masked writes
    do_write(8'h00, 32'h00FF_00A5);
    check("R2 low byte set", pin_out, 32'h0000_00A5);
    do_write(8'h00, 32'h0001_0000);
    check("R2 single bit cleared, rest kept", pin_out, 32'h0000_00A4);
    do_write(8'h00, 32'h0000_FFFF);
    check("R2 no enables no change", pin_out, 32'h0000_00A4);

    // R3 halves
    do_write(8'h04, 32'hFFFF_1234);
    check("R3 high half", pin_out, 32'h1234_00A4);
    // R4 read format
    do_read(8'h04, 32'h0000_1234, "R4 read high half");
    do_read(8'h00, 32'h0000_00A4, "R4 read low half");

    // R5 direction
    do_write(8'h08, 32'hFFFF_F00F);
    do_write(8'h0C, 32'h8000_8000);
    check("R5 pin_oe", pin_oe, 32'h8000_F00F);
    check("R5 pin_out unchanged", pin_out, 32'h1234_00A4);

    // R6 interrupt configuration offsets
    do_write(8'h10, 32'hFFFF_0001);
    do_write(8'h18, 32'hFFFF_0002);
    do_write(8'h20, 32'hFFFF_0004);
    do_write(8'h2C, 32'h0001_0001);
    do_write(8'h30, 32'hFFFF_0010);
    do_write(8'h3C, 32'hFFFF_AAAA);
    check("R6 irq_en", irq_en, 32'h0000_0001);
    check("R6 irq_mask", irq_mask, 32'h0000_0002);
    check("R6 irq_edge", irq_edge, 32'h0000_0004);
    check("R6 irq_pol", irq_pol, 32'h0001_0000);
    check("R6 irq_both", irq_both, 32'h0000_0010);
    check("R6 irq_debounce", irq_debounce, 32'hAAAA_0000);
    do_read(8'h3C, 32'h0000_AAAA, "R6 debounce readback");

    // R7 synchronized pin levels
    pin_in = 32'hCAFE_BEEF;
    repeat (4) @(negedge clk);
    do_read(8'h70, 32'h0000_BEEF, "R7 ext low");
    do_read(8'h74, 32'h0000_CAFE, "R7 ext high");
    pin_in = 32'hCAFE_0123;
    do_read(8'h70, 32'h0000_BEEF, "R7 edge k+1 old");
    do_read(8'h70, 32'h0000_BEEF, "R7 edge k+1 still old");
    do_read(8'h70, 32'h0000_0123, "R7 edge k+2 new");

    // R8 detector status passthrough
    irq_status_in = 32'h1234_5678;
    irq_raw_in    = 32'h9ABC_DEF0;
    do_read(8'h50, 32'h0000_5678, "R8 status low");
    do_read(8'h54, 32'h0000_1234, "R8 status high");
    do_read(8'h58, 32'h0000_DEF0, "R8 raw low");
    do_read(8'h5C, 32'h0000_9ABC, "R8 raw high");

    // R9 end-of-interrupt pulse
    do_write(8'h60, 32'h000F_0005);
    check("R9 eoi low pulse", eoi_pulse, 32'h0000_0005);
    @(negedge clk);
    check("R9 eoi one cycle", eoi_pulse, 32'h0);
    do_write(8'h64, 32'h8000_FFFF);
    check("R9 eoi high pulse", eoi_pulse, 32'h8000_0000);
    do_read(8'h60, 32'h0, "R9 eoi reads zero");

    // R10 version
    do_read(8'h78, 32'h0100_0C2B, "R10 version");
    do_write(8'h78, 32'hFFFF_0000);
    do_read(8'h78, 32'h0100_0C2B, "R10 version after write");

    // R11 unmapped offsets
    do_write(8'h01, 32'hFFFF_FFFF);
    check("R11 unaligned write ignored", pin_out, 32'h1234_00A4);
    do_write(8'h09, 32'hFFFF_0000);
    check("R11 unaligned dir write ignored", pin_oe, 32'h8000_F00F);
    do_write(8'h40, 32'hFFFF_FFFF);
    do_read(8'h40, 32'h0, "R11 gap read");
    do_read(8'h7C, 32'h0, "R11 0x7C read");
    do_read(8'h80, 32'h0, "R11 above window");
    do_read(8'h09, 32'h0, "R11 unaligned read");
    do_read(8'h08, 32'h0000_F00F, "R11 dir intact");

    // R12 same-cycle read and write
    do_rw(8'h00, 32'h00FF_0000, 32'h0000_00A4, "R12 read sees old value");
    do_read(8'h00, 32'h0000_0000, "R12 merged value after");
    check("R12 pin_out after", pin_out, 32'h1234_0000);

    repeat (3) @(negedge clk);
    check("R4 scoreboard drained", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule